// File: doc/BRIEF.md
# Serial Security Register Program Engine

This block is a serial-peripheral slave that takes a one-time-programmable write command on a single data-in line and applies it to three 256-byte security registers held inside the block. The serial pins are oversampled by the system clock. A frame is an opcode byte, a 24-bit address and one or more data bytes, all sent most significant bit first. The address names one of the three registers and a starting byte offset. The data bytes are collected in a staging buffer. They are written to the store only when chip select is released cleanly.

The engine checks the external write-enable latch when the opcode completes. It checks the lock bit of the addressed register when the address completes. A program can only clear bits, because each stored byte becomes the bitwise AND of its old value and the new value. After a command that commits, or one that is dropped only because its register is locked, the block pulses an output that tells the owner of the latch to clear it. A read port gives any byte of the store combinationally.

Top module: `secreg_prog_engine`

## Requirements
- R1: After reset every byte of all three registers reads 0xFF and `wel_clr_o` is low.
- R2: Only opcode 0x42, sampled MSB first on rising SCK edges while chip select is low, starts a program; any other opcode leaves the store and `wel_clr_o` untouched.
- R3: If `wel_i` is 0 when the opcode completes, the command has no effect on the store or on `wel_clr_o`.
- R4: Address bits 15:12 select the register (1 to read index 0, 2 to index 1, 3 to index 2, read through `rd_sel_i`). Bits 7:0 give the starting byte offset.
- R5: A command is dropped, with no store change and no clear pulse, when address bits 23:16 or 11:8 are nonzero or bits 15:12 are not 1, 2 or 3.
- R6: When the lock bit `lock_i[n]` of the addressed register index n is 1, the register keeps its contents, but the command still produces a clear pulse.
- R7: Each programmed byte becomes the AND of its previous value and the received byte.
- R8: Bytes commit only at chip-select release, and only when at least one full data byte has arrived and no partial byte is pending. Otherwise the whole command is discarded and no clear pulse is produced.
- R9: The offset wraps from 0xFF to 0x00 within the same register. When more than 256 bytes are sent, the last byte written to each offset is the one kept.
- R10: `wel_clr_o` is a single-cycle pulse that occurs only after chip-select release, once per accepted or lock-dropped command.
- R11: Frames work both with SCK idling low and with SCK idling high.
- R12: A chip-select falling edge always restarts decoding at the opcode, whatever the previous frame left behind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the serial pins |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Serial chip select, active low |
| sck_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data in |
| wel_i | input | 1 | Write-enable latch state |
| lock_i | input | NUM_REGS | Per-register lock bits, bit n for register index n |
| wel_clr_o | output | 1 | One-cycle request to clear the write-enable latch |
| rd_sel_i | input | $clog2(NUM_REGS) | Read register index |
| rd_ofs_i | input | $clog2(REG_BYTES) | Read byte offset |
| rd_data_o | output | 8 | Byte at the selected register and offset |

## Verification
The bench builds the block with its default parameters: three 256-byte registers, a two-stage pin synchronizer and opcode 0x42. The serial clock runs at four system clocks per half period. The full 256-byte offset range makes both the offset wrap and a 258-byte overrun reachable in short runs. Having three registers means one can be locked while the other two still accept writes. After each frame a behavioural model of the store is compared with the read port on every clock, and the clear pulse is counted in a fixed window after release.

// File: rtl/secreg_pkg.sv
package secreg_pkg;
  localparam int unsigned ADDR_BITS = 24;
  localparam int unsigned BYTE_BITS = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPC,
    ST_ADDR,
    ST_DATA,
    ST_DROP
  } dec_state_e;
endpackage

// File: rtl/secreg_pin_sync.sv
module secreg_pin_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sck_i,
  input  logic sdi_i,
  output logic cs_high_o,
  output logic cs_fall_o,
  output logic cs_rise_o,
  output logic sck_rise_o,
  output logic sdi_o
);
  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] cs_q, sck_q, sdi_q;
  logic cs_d, sck_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q  <= '1;
      sck_q <= '0;
      sdi_q <= '0;
      cs_d  <= 1'b1;
      sck_d <= 1'b0;
    end else begin
      cs_q  <= {cs_q[SYNC_STAGES-2:0], cs_ni};
      sck_q <= {sck_q[SYNC_STAGES-2:0], sck_i};
      sdi_q <= {sdi_q[SYNC_STAGES-2:0], sdi_i};
      cs_d  <= cs_q[LAST];
      sck_d <= sck_q[LAST];
    end
  end

  assign cs_high_o  = cs_q[LAST];
  assign cs_fall_o  = cs_d & ~cs_q[LAST];
  assign cs_rise_o  = ~cs_d & cs_q[LAST];
  assign sck_rise_o = ~sck_d & sck_q[LAST];
  assign sdi_o      = sdi_q[LAST];
endmodule

// File: rtl/secreg_cmd_decoder.sv
module secreg_cmd_decoder
  import secreg_pkg::*;
#(
  parameter int unsigned NUM_REGS  = 3,
  parameter int unsigned REG_BYTES = 256,
  parameter logic [7:0]  OPCODE    = 8'h42,
  localparam int unsigned SEL_W    = $clog2(NUM_REGS),
  localparam int unsigned OFS_W    = $clog2(REG_BYTES)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          cs_high_i,
  input  logic                          cs_fall_i,
  input  logic                          cs_rise_i,
  input  logic                          sck_rise_i,
  input  logic                          sdi_i,
  input  logic                          wel_i,
  input  logic [NUM_REGS-1:0]           lock_i,
  output logic                          commit_o,
  output logic [SEL_W-1:0]              sel_o,
  output logic [REG_BYTES-1:0]          valid_o,
  output logic [REG_BYTES-1:0][7:0]     data_o,
  output logic                          wel_clr_o
);
  localparam logic [3:0] MAX_FIELD = 4'(NUM_REGS);

  dec_state_e              state;
  logic [4:0]              bit_cnt;
  logic [ADDR_BITS-1:0]    shreg;
  logic [ADDR_BITS-1:0]    shift_next;
  logic [OFS_W-1:0]        ofs;
  logic                    locked;
  logic                    got_byte;
  logic [3:0]              reg_field;
  logic                    addr_ok;
  logic                    lock_hit;
  logic                    byte_done;

  assign shift_next = {shreg[ADDR_BITS-2:0], sdi_i};
  assign reg_field  = shift_next[15:12];
  assign addr_ok    = (shift_next[23:16] == 8'h00) && (shift_next[11:8] == 4'h0) &&
                      (reg_field != 4'h0) && (reg_field <= MAX_FIELD);
  assign byte_done  = sck_rise_i && !cs_high_i && (state == ST_DATA) && (bit_cnt == 5'd7);

  always_comb begin
    lock_hit = 1'b0;
    for (int r = 0; r < NUM_REGS; r++) begin
      if (reg_field == 4'(r + 1) && lock_i[r]) lock_hit = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state     <= ST_IDLE;
      bit_cnt   <= '0;
      shreg     <= '0;
      ofs       <= '0;
      sel_o     <= '0;
      locked    <= 1'b0;
      got_byte  <= 1'b0;
      valid_o   <= '0;
      commit_o  <= 1'b0;
      wel_clr_o <= 1'b0;
    end else begin
      commit_o  <= 1'b0;
      wel_clr_o <= 1'b0;
      if (cs_fall_i) begin
        state    <= ST_OPC;
        bit_cnt  <= '0;
        valid_o  <= '0;
        got_byte <= 1'b0;
      end else if (cs_rise_i) begin
        // release on a byte boundary after at least one data byte
        if (state == ST_DATA && got_byte && bit_cnt == 5'd0) begin
          commit_o  <= !locked;
          wel_clr_o <= 1'b1;
        end
        state <= ST_IDLE;
      end else if (sck_rise_i && !cs_high_i) begin
        unique case (state)
          ST_OPC: begin
            shreg   <= shift_next;
            bit_cnt <= bit_cnt + 5'd1;
            if (bit_cnt == 5'd7) begin
              bit_cnt <= '0;
              state   <= (shift_next[7:0] == OPCODE && wel_i) ? ST_ADDR : ST_DROP;
            end
          end
          ST_ADDR: begin
            shreg   <= shift_next;
            bit_cnt <= bit_cnt + 5'd1;
            if (bit_cnt == 5'(ADDR_BITS - 1)) begin
              bit_cnt <= '0;
              sel_o   <= SEL_W'(reg_field - 4'd1);
              ofs     <= shift_next[OFS_W-1:0];
              locked  <= lock_hit;
              state   <= addr_ok ? ST_DATA : ST_DROP;
            end
          end
          ST_DATA: begin
            shreg   <= shift_next;
            bit_cnt <= bit_cnt + 5'd1;
            if (bit_cnt == 5'd7) begin
              bit_cnt      <= '0;
              valid_o[ofs] <= 1'b1;
              ofs          <= ofs + OFS_W'(1);
              got_byte     <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // staging buffer needs no reset: valid_o qualifies every entry
  always_ff @(posedge clk_i) begin
    if (byte_done) data_o[ofs] <= shift_next[7:0];
  end

  assert_clr_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wel_clr_o |=> !wel_clr_o);
  assert_clr_after_release_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wel_clr_o |-> $past(cs_rise_i));
  assert_commit_has_bytes_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> (valid_o != '0));
  assert_commit_clears_wel_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> wel_clr_o);
endmodule

// File: rtl/secreg_store.sv
module secreg_store #(
  parameter int unsigned NUM_REGS  = 3,
  parameter int unsigned REG_BYTES = 256,
  localparam int unsigned SEL_W    = $clog2(NUM_REGS),
  localparam int unsigned OFS_W    = $clog2(REG_BYTES)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      commit_i,
  input  logic [SEL_W-1:0]          sel_i,
  input  logic [REG_BYTES-1:0]      valid_i,
  input  logic [REG_BYTES-1:0][7:0] data_i,
  input  logic [SEL_W-1:0]          rd_sel_i,
  input  logic [OFS_W-1:0]          rd_ofs_i,
  output logic [7:0]                rd_data_o
);
  logic [7:0] mem [NUM_REGS][REG_BYTES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < NUM_REGS; r++) begin
        for (int b = 0; b < REG_BYTES; b++) mem[r][b] <= 8'hFF;
      end
    end else if (commit_i) begin
      for (int b = 0; b < REG_BYTES; b++) begin
        if (valid_i[b]) mem[sel_i][b] <= mem[sel_i][b] & data_i[b];
      end
    end
  end

  assign rd_data_o = (32'(rd_sel_i) < NUM_REGS) ? mem[rd_sel_i][rd_ofs_i] : 8'hFF;

  assert_sel_in_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |-> (32'(sel_i) < NUM_REGS));
endmodule

// File: rtl/secreg_prog_engine.sv
module secreg_prog_engine #(
  parameter int unsigned NUM_REGS    = 3,
  parameter int unsigned REG_BYTES   = 256,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [7:0]  OPCODE      = 8'h42
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         cs_ni,
  input  logic                         sck_i,
  input  logic                         sdi_i,
  input  logic                         wel_i,
  input  logic [NUM_REGS-1:0]          lock_i,
  output logic                         wel_clr_o,
  input  logic [$clog2(NUM_REGS)-1:0]  rd_sel_i,
  input  logic [$clog2(REG_BYTES)-1:0] rd_ofs_i,
  output logic [7:0]                   rd_data_o
);
  localparam int unsigned SEL_W = $clog2(NUM_REGS);

  logic cs_high, cs_fall, cs_rise, sck_rise, sdi_s;
  logic commit;
  logic [SEL_W-1:0] sel;
  logic [REG_BYTES-1:0] valid;
  logic [REG_BYTES-1:0][7:0] stage;

  secreg_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .cs_ni, .sck_i, .sdi_i,
    .cs_high_o(cs_high), .cs_fall_o(cs_fall), .cs_rise_o(cs_rise),
    .sck_rise_o(sck_rise), .sdi_o(sdi_s)
  );

  secreg_cmd_decoder #(.NUM_REGS(NUM_REGS), .REG_BYTES(REG_BYTES), .OPCODE(OPCODE)) u_dec (
    .clk_i, .rst_ni,
    .cs_high_i(cs_high), .cs_fall_i(cs_fall), .cs_rise_i(cs_rise),
    .sck_rise_i(sck_rise), .sdi_i(sdi_s), .wel_i, .lock_i,
    .commit_o(commit), .sel_o(sel), .valid_o(valid), .data_o(stage), .wel_clr_o
  );

  secreg_store #(.NUM_REGS(NUM_REGS), .REG_BYTES(REG_BYTES)) u_store (
    .clk_i, .rst_ni, .commit_i(commit), .sel_i(sel), .valid_i(valid), .data_i(stage),
    .rd_sel_i, .rd_ofs_i, .rd_data_o
  );
endmodule

// File: tb/secreg_prog_engine_tb.sv
`timescale 1ns/1ps
module secreg_prog_engine_tb_top;
  typedef logic [7:0] bq_t[$];

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, sdi = 1'b0, wel = 1'b1;
  logic [2:0] lock = 3'b100;
  logic wel_clr;
  logic [1:0] rd_sel = '0;
  logic [7:0] rd_ofs = '0;
  logic [7:0] rd_data;

  int checks = 0;
  int errors = 0;
  logic [7:0] mdl [3][256];

  always #2.5 clk = ~clk;

  secreg_prog_engine dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck), .sdi_i(sdi),
    .wel_i(wel), .lock_i(lock), .wel_clr_o(wel_clr),
    .rd_sel_i(rd_sel), .rd_ofs_i(rd_ofs), .rd_data_o(rd_data)
  );

  // R10: no clear request while a frame is in progress
  always @(negedge clk) begin
    if (rst_n && !cs_n) begin
      checks++;
      if (wel_clr) begin
        errors++;
        $display("FAIL R10 clear pulse during frame: got %0b exp 0", wel_clr);
      end
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sweep(input string tag);
    for (int r = 0; r < 3; r++) begin
      for (int b = 0; b < 256; b++) begin
        @(negedge clk);
        rd_sel = 2'(r);
        rd_ofs = 8'(b);
        #1;
        checks++;
        if (rd_data !== mdl[r][b]) begin
          errors++;
          $display("FAIL %s reg %0d ofs %0d: got %02h exp %02h", tag, r, b, rd_data, mdl[r][b]);
        end
      end
    end
  endtask

  function automatic bq_t frame(input logic [7:0] opc, input logic [23:0] addr,
                                input int n, input int seed);
    bq_t q;
    q.push_back(opc);
    q.push_back(addr[23:16]);
    q.push_back(addr[15:8]);
    q.push_back(addr[7:0]);
    for (int i = 0; i < n; i++) q.push_back(8'((seed + i * 37) & 255));
    return q;
  endfunction

  task automatic run_cmd(input bq_t q, input int extra, input bit mode3,
                         input bit wel_v, input string tag);
    logic [23:0] addr;
    int regf, ofs, pulses;
    bit ok, apply;
    logic [7:0] tbuf [256];
    bit tval [256];
    ok = wel_v && extra == 0 && q.size() >= 5 && q[0] == 8'h42;
    addr = (q.size() >= 4) ? {q[1], q[2], q[3]} : 24'hFFFFFF;
    regf = int'(addr[15:12]);
    ofs = int'(addr[7:0]);
    ok = ok && addr[23:16] == 8'h00 && addr[11:8] == 4'h0 && regf >= 1 && regf <= 3;
    apply = ok && !lock[regf - 1];
    wel = wel_v;
    sck = mode3;
    wait_clk(4);
    cs_n = 1'b0;
    wait_clk(4);
    for (int i = 0; i < q.size() * 8 + extra; i++) begin
      logic bv;
      bv = (i < q.size() * 8) ? q[i / 8][7 - (i % 8)] : 1'b1;
      if (mode3) sck = 1'b0;
      sdi = bv;
      wait_clk(4);
      sck = 1'b1;
      wait_clk(4);
      if (!mode3) sck = 1'b0;
    end
    wait_clk(4);
    cs_n = 1'b1;
    pulses = 0;
    for (int c = 0; c < 12; c++) begin
      @(negedge clk);
      if (wel_clr) pulses++;
    end
    checks++;
    if (pulses != (ok ? 1 : 0)) begin
      errors++;
      $display("FAIL %s clear pulses: got %0d exp %0d", tag, pulses, ok ? 1 : 0);
    end
    if (apply) begin
      for (int i = 0; i < 256; i++) tval[i] = 1'b0;
      for (int i = 4; i < q.size(); i++) begin
        tbuf[(ofs + i - 4) % 256] = q[i];
        tval[(ofs + i - 4) % 256] = 1'b1;
      end
      for (int i = 0; i < 256; i++)
        if (tval[i]) mdl[regf - 1][i] = mdl[regf - 1][i] & tbuf[i];
    end
    sweep(tag);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bq_t q;
    for (int r = 0; r < 3; r++)
      for (int b = 0; b < 256; b++) mdl[r][b] = 8'hFF;
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(2);
    checks++;
    if (wel_clr !== 1'b0) begin
      errors++;
      $display("FAIL R1 clear after reset: got %0b exp 0", wel_clr);
    end
    sweep("R1");

    // R4 R7: register 1, offset 0x10
    q = {8'h42, 8'h00, 8'h10, 8'h10, 8'h0F, 8'hA5};
    run_cmd(q, 0, 1'b0, 1'b1, "R4");
    q = {8'h42, 8'h00, 8'h10, 8'h10, 8'hF0, 8'h3C};
    run_cmd(q, 0, 1'b0, 1'b1, "R7");
    run_cmd(frame(8'h42, 24'h002040, 3, 5), 0, 1'b0, 1'b1, "R4");
    run_cmd(frame(8'h42, 24'h002050, 4, 9), 0, 1'b0, 1'b0, "R3");
    run_cmd(frame(8'h02, 24'h002050, 4, 9), 0, 1'b0, 1'b1, "R2");
    run_cmd(frame(8'h42, 24'h004000, 2, 1), 0, 1'b0, 1'b1, "R5");
    run_cmd(frame(8'h42, 24'h000000, 2, 1), 0, 1'b0, 1'b1, "R5");
    run_cmd(frame(8'h42, 24'h011000, 2, 1), 0, 1'b0, 1'b1, "R5");
    run_cmd(frame(8'h42, 24'h001100, 2, 1), 0, 1'b0, 1'b1, "R5");
    run_cmd(frame(8'h42, 24'h003020, 3, 2), 0, 1'b0, 1'b1, "R6");
    run_cmd(frame(8'h42, 24'h003020, 1, 2), 3, 1'b0, 1'b1, "R6");
    run_cmd(frame(8'h42, 24'h001060, 2, 3), 3, 1'b0, 1'b1, "R8");
    run_cmd(frame(8'h42, 24'h001060, 0, 3), 0, 1'b0, 1'b1, "R8");
    run_cmd(frame(8'h42, 24'h0020FE, 4, 11), 0, 1'b0, 1'b1, "R9");
    run_cmd(frame(8'h42, 24'h001000, 258, 77), 0, 1'b0, 1'b1, "R9");
    run_cmd(frame(8'h42, 24'h002080, 5, 13), 0, 1'b1, 1'b1, "R11");
    q = {8'h42, 8'h00};
    run_cmd(q, 5, 1'b1, 1'b1, "R12");
    run_cmd(frame(8'h42, 24'h0030A0, 2, 21), 0, 1'b0, 1'b1, "R12");
    run_cmd(frame(8'h42, 24'h0010A0, 2, 21), 0, 1'b0, 1'b1, "R12");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule